// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is a 32-bit integer arithmetic and logic unit paired with a packed 32-bit status word. It performs add, add-with-carry, subtract, subtract-with-borrow, AND, OR and XOR. The result is combinational from the operands, the operation code and the stored carry bit. On the next rising clock edge, the six status bits (carry, parity, half carry, zero, sign, overflow) are written into the status word.

The carry-chained operations take their carry-in or borrow-in from the stored carry bit. A caller can therefore add or subtract values wider than one word, one word per cycle, lowest word first. A direct write port loads the whole status word, including the control bits (trap, interrupt enable, direction, privilege level and the others). Bit positions that are fixed are forced on every write. When the status update enable is low, the result is still computed but the status word keeps its value.

Top module: `int_alu_flags`

## Requirements
- R1: Operation code 0 (add) gives result = a + b modulo 2^32. Bit 0 (carry) is set when the sum carries out of bit 31.
- R2: Operation codes 1 (add with carry) and 3 (subtract with borrow) add or subtract the stored bit 0 as carry-in or borrow-in. A 64-bit sum or difference can therefore be built from two consecutive operations, low word first.
- R3: Operation codes 2 (subtract) and 3 give result = a - b - borrow modulo 2^32. Bit 0 is set exactly when the unsigned value of a is less than b plus the borrow-in.
- R4: Bit 11 (overflow) is set when a signed add or subtract result does not fit in 32 bits.
- R5: Bit 2 (parity) is set when result bits 7:0 hold an even number of ones. Bits 31:8 have no effect on it.
- R6: Bit 4 (half carry) is set on a carry out of bit 3 for additions, or on a borrow into bit 3 for subtractions.
- R7: Bit 6 (zero) is set when the result is all zeros. Bit 7 (sign) equals result bit 31.
- R8: Operation codes 4, 5 and 6 (AND, OR, XOR) clear bit 0 and bit 11, leave bit 4 unchanged, and set bits 2, 6 and 7 from the result.
- R9: When the update enable is low, the result is still produced but the status word keeps its previous value.
- R10: A direct write loads the status word with bit 1 forced to 1 and bits 3, 5, 15 and 31:22 forced to 0. A direct write takes priority over a status update in the same cycle.
- R11: An arithmetic or logic update never changes bits other than 0, 2, 4, 6, 7 and 11. In particular, control bits 8 (trap), 9 (interrupt enable), 10 (direction) and 21:12 are preserved.
- R12: After reset the status word reads 0x00000002. A status update or direct write is visible at the output after the next rising clock edge.
- R13: Operation code 7 gives a zero result and never changes the status word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| opnd_a | input | 32 | First operand (minuend for subtracts) |
| opnd_b | input | 32 | Second operand (subtrahend for subtracts) |
| op_code | input | 3 | Operation select, encoding as in R1-R13 |
| flag_upd_en | input | 1 | Write status bits from this operation at the next edge |
| fw_en | input | 1 | Direct write of the status word |
| fw_data | input | 32 | Value for the direct write |
| alu_out | output | 32 | Combinational result |
| flags_out | output | 32 | Registered status word |

## Verification
`alu_out` is combinational, so the bench samples it one time unit after driving the inputs on a falling edge, before any clock edge. The status word passes through a single register. The bench therefore compares `flags_out` at the falling edge that follows the next rising edge, one cycle after the stimulus. The carry-chained cases depend on that timing, because their expected result uses the carry stored by the previous step. A bench model of the status word advances only after each registered check.

// File: rtl/alu_flags_pkg.sv
// Package: shared operation codes, status-word bit positions and fixed masks.
// Assumes a 32-bit packed status word whose layout does not depend on operand width.
package alu_flags_pkg;

    localparam int FLAGS_W = 32;

    // Operation encodings seen on op_code
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBB  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_NONE = 3'd7
    } alu_op_e;

    // Status bit positions (decoded by neighbouring logic, so fixed)
    localparam int BIT_CARRY = 0;
    localparam int BIT_PAR   = 2;
    localparam int BIT_HALF  = 4;
    localparam int BIT_ZERO  = 6;
    localparam int BIT_SIGN  = 7;
    localparam int BIT_TRAP  = 8;
    localparam int BIT_INTEN = 9;
    localparam int BIT_DIR   = 10;
    localparam int BIT_OVF   = 11;

    // Fixed positions: bit 1 reads one; 3, 5, 15 and 31:22 read zero
    localparam logic [FLAGS_W-1:0] FIXED_ONE  = 32'h0000_0002;
    localparam logic [FLAGS_W-1:0] FIXED_ZERO = 32'hFFC0_8028;
    localparam logic [FLAGS_W-1:0] FLAGS_RST  = FIXED_ONE;

    // Bits an arithmetic/logic update may change
    localparam logic [FLAGS_W-1:0] STATUS_MASK =
        (32'd1 << BIT_CARRY) | (32'd1 << BIT_PAR)  | (32'd1 << BIT_HALF) |
        (32'd1 << BIT_ZERO)  | (32'd1 << BIT_SIGN) | (32'd1 << BIT_OVF);

    // Bits that keep their value through any status update
    localparam logic [FLAGS_W-1:0] HOLD_MASK = ~STATUS_MASK;

    // Status produced by one operation
    typedef struct packed {
        logic carry;
        logic parity;
        logic half;
        logic zero;
        logic sign;
        logic ovf;
    } status_t;

endpackage

// File: rtl/alu_addsub.sv
// Adder/subtractor: computes a + b + cin or a - b - bin in one carry chain.
// Subtraction is done as a + ~b + ~bin, so the chain carry out is the inverse
// of the borrow. Assumes W >= 8 so that bit 4 exists.
module alu_addsub #(
    parameter int W = 32
) (
    input  logic         sub,
    input  logic         cin,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         half,
    output logic         ovf
);
    localparam int EXT_W = W + 1;

    logic [W-1:0]     b_eff;
    logic             c_eff;
    logic [EXT_W-1:0] ext;

    // Invert the second operand and carry for subtraction, then add
    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = sub ? ~cin : cin;
        ext   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    end

    // Derive result, carry/borrow, bit-3 carry and signed overflow
    always_comb begin
        res   = ext[W-1:0];
        carry = sub ? ~ext[W] : ext[W];
        half  = a[4] ^ b[4] ^ ext[4];
        ovf   = (a[W-1] == b_eff[W-1]) && (ext[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
// Bitwise unit: AND, OR or XOR of the operands, chosen by a 2-bit select.
// Select 0 = AND, 1 = OR, 2 = XOR, 3 = zero. Built per bit with a generate loop.
module alu_logic #(
    parameter int W = 32
) (
    input  logic [1:0]   sel,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // One bit slice of the selected function
        always_comb begin
            unique case (sel)
                2'd0:    res[i] = a[i] & b[i];
                2'd1:    res[i] = a[i] | b[i];
                2'd2:    res[i] = a[i] ^ b[i];
                default: res[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/alu_result_status.sv
// Result-derived status: parity of the low byte, zero and sign.
// Assumes W >= 8. Parity is set for an even count of ones in bits 7:0.
module alu_result_status #(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    output logic         parity,
    output logic         zero,
    output logic         sign
);
    localparam int PAR_BITS = 8;

    // Fold the low byte into an odd-count bit, then invert for even parity
    always_comb begin
        logic odd;
        odd = 1'b0;
        for (int i = 0; i < PAR_BITS; i++) odd = odd ^ res[i];
        parity = ~odd;
    end

    // Zero and sign come straight from the whole result
    always_comb begin
        zero = (res == '0);
        sign = res[W-1];
    end
endmodule

// File: rtl/alu_flag_reg.sv
// Packed status word register. A direct write loads every non-fixed bit.
// A status update writes only the six status bits. The direct write wins
// when both occur. Fixed bits are forced on every load.
module alu_flag_reg
    import alu_flags_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               st_we,
    input  status_t            st_nxt,
    input  logic               wr_en,
    input  logic [FLAGS_W-1:0] wr_data,
    output logic [FLAGS_W-1:0] q
);
    // Hold, load directly, or merge new status bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= FLAGS_RST;
        end else if (wr_en) begin
            q <= (wr_data & ~FIXED_ZERO) | FIXED_ONE;
        end else if (st_we) begin
            q[BIT_CARRY] <= st_nxt.carry;
            q[BIT_PAR]   <= st_nxt.parity;
            q[BIT_HALF]  <= st_nxt.half;
            q[BIT_ZERO]  <= st_nxt.zero;
            q[BIT_SIGN]  <= st_nxt.sign;
            q[BIT_OVF]   <= st_nxt.ovf;
        end
    end

    // R10: fixed positions keep their constant values
    p_fixed_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((q & FIXED_ZERO) == '0) && q[1]);

    // R10: a direct write lands one cycle later with fixed bits forced
    p_direct_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> q == (($past(wr_data) & ~FIXED_ZERO) | FIXED_ONE));

    // R9: with neither write source active the word is stable
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !st_we) |=> $stable(q));

    // R11: a status update leaves every other bit alone
    p_ctrl_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && !wr_en) |=> (q & HOLD_MASK) == ($past(q) & HOLD_MASK));
endmodule

// File: rtl/int_alu_flags.sv
// Top: integer ALU with a packed status word.
// Decodes the operation, chains the stored carry into add-with-carry and
// subtract-with-borrow, selects the result and feeds the status register.
// Assumes DATA_W >= 8. The result is combinational; the status is registered.
module int_alu_flags
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    input  logic [2:0]         op_code,
    input  logic               flag_upd_en,
    input  logic               fw_en,
    input  logic [FLAGS_W-1:0] fw_data,
    output logic [DATA_W-1:0]  alu_out,
    output logic [FLAGS_W-1:0] flags_out
);
    alu_op_e     op;
    logic        is_arith;
    logic        is_logic;
    logic        is_sub;
    logic        use_cin;
    logic [1:0]  lg_sel;
    logic        chain_in;
    logic [DATA_W-1:0] as_res;
    logic [DATA_W-1:0] lg_res;
    logic        as_carry;
    logic        as_half;
    logic        as_ovf;
    logic        r_par;
    logic        r_zero;
    logic        r_sign;
    status_t     st_nxt;
    logic        st_we;

    assign op = alu_op_e'(op_code);

    // Decode the operation class and sub-function
    always_comb begin
        is_arith = 1'b0;
        is_logic = 1'b0;
        is_sub   = 1'b0;
        use_cin  = 1'b0;
        lg_sel   = 2'd3;
        unique case (op)
            OP_ADD:  is_arith = 1'b1;
            OP_ADC:  begin is_arith = 1'b1; use_cin = 1'b1; end
            OP_SUB:  begin is_arith = 1'b1; is_sub = 1'b1; end
            OP_SBB:  begin is_arith = 1'b1; is_sub = 1'b1; use_cin = 1'b1; end
            OP_AND:  begin is_logic = 1'b1; lg_sel = 2'd0; end
            OP_OR:   begin is_logic = 1'b1; lg_sel = 2'd1; end
            OP_XOR:  begin is_logic = 1'b1; lg_sel = 2'd2; end
            default: ;
        endcase
    end

    // Carry or borrow in comes from the stored carry bit
    assign chain_in = use_cin & flags_out[BIT_CARRY];

    alu_addsub #(.W(DATA_W)) u_addsub (
        .sub   (is_sub),
        .cin   (chain_in),
        .a     (opnd_a),
        .b     (opnd_b),
        .res   (as_res),
        .carry (as_carry),
        .half  (as_half),
        .ovf   (as_ovf)
    );

    alu_logic #(.W(DATA_W)) u_logic (
        .sel (lg_sel),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (lg_res)
    );

    // Select the result of the active unit; unused code yields zero
    always_comb begin
        if (is_arith)      alu_out = as_res;
        else if (is_logic) alu_out = lg_res;
        else               alu_out = '0;
    end

    alu_result_status #(.W(DATA_W)) u_rstat (
        .res    (alu_out),
        .parity (r_par),
        .zero   (r_zero),
        .sign   (r_sign)
    );

    // Assemble the next status; logic ops clear carry/overflow, keep half carry
    always_comb begin
        st_nxt.carry  = is_arith & as_carry;
        st_nxt.ovf    = is_arith & as_ovf;
        st_nxt.half   = is_arith ? as_half : flags_out[BIT_HALF];
        st_nxt.parity = r_par;
        st_nxt.zero   = r_zero;
        st_nxt.sign   = r_sign;
        st_we         = flag_upd_en & (is_arith | is_logic);
    end

    alu_flag_reg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_we   (st_we),
        .st_nxt  (st_nxt),
        .wr_en   (fw_en),
        .wr_data (fw_data),
        .q       (flags_out)
    );

    // R13: code 7 produces zero and never moves the status word
    p_none_op_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd7 && !fw_en) |=> $stable(flags_out));

    // R8: logic operations leave carry and overflow cleared
    p_logic_cv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd_en && !fw_en && op_code[2] && op_code != 3'd7)
        |=> (!flags_out[BIT_CARRY] && !flags_out[BIT_OVF]));

    // R7: the stored zero bit matches the result of the updating operation
    p_zero_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd_en && !fw_en && op_code != 3'd7)
        |=> flags_out[BIT_ZERO] == ($past(alu_out) == '0));

    // R7: the stored sign bit matches the result's top bit
    p_sign_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd_en && !fw_en && op_code != 3'd7)
        |=> flags_out[BIT_SIGN] == $past(alu_out[DATA_W-1]));

    // R9: with the update enable low the word does not change
    p_no_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_upd_en && !fw_en) |=> $stable(flags_out));
endmodule

// File: tb/tb_int_alu_flags.sv
module tb_int_alu_flags;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [2:0]  op_code = 3'd7;
    logic        flag_upd_en = 1'b0;
    logic        fw_en = 1'b0;
    logic [31:0] fw_data = '0;
    logic [31:0] alu_out;
    logic [31:0] flags_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] model = 32'h2;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_alu_flags dut (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .op_code(op_code), .flag_upd_en(flag_upd_en), .fw_en(fw_en),
        .fw_data(fw_data), .alu_out(alu_out), .flags_out(flags_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference result from the requirement text
    function automatic logic [31:0] ref_res(input logic [2:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic cf);
        logic [32:0] t;
        case (op)
            3'd0: t = {1'b0, a} + {1'b0, b};
            3'd1: t = {1'b0, a} + {1'b0, b} + {32'd0, cf};
            3'd2: t = {1'b0, a} - {1'b0, b};
            3'd3: t = {1'b0, a} - {1'b0, b} - {32'd0, cf};
            3'd4: t = {1'b0, a & b};
            3'd5: t = {1'b0, a | b};
            3'd6: t = {1'b0, a ^ b};
            default: t = '0;
        endcase
        return t[31:0];
    endfunction

    // Reference next status word
    function automatic logic [31:0] ref_flags(input logic [2:0] op, input logic [31:0] a,
                                              input logic [31:0] b, input logic [31:0] old);
        logic [31:0] r, n;
        logic [32:0] s;
        logic ci, c, h, v;
        r = ref_res(op, a, b, old[0]);
        n = old;
        if (op == 3'd7) return old;
        ci = (op == 3'd1 || op == 3'd3) ? old[0] : 1'b0;
        if (op <= 3'd1) begin
            s = {1'b0, a} + {1'b0, b} + {32'd0, ci};
            c = s[32];
            h = ({28'd0, a[3:0]} + {28'd0, b[3:0]} + {31'd0, ci}) > 32'd15;
            v = (a[31] == b[31]) && (r[31] != a[31]);
        end else if (op <= 3'd3) begin
            c = {1'b0, a} < ({1'b0, b} + {32'd0, ci});
            h = {1'b0, a[3:0]} < ({1'b0, b[3:0]} + {4'd0, ci});
            v = (a[31] != b[31]) && (r[31] != a[31]);
        end else begin
            c = 1'b0; h = old[4]; v = 1'b0;
        end
        n[0] = c; n[4] = h; n[11] = v;
        n[2] = ($countones(r[7:0]) % 2) == 0;
        n[6] = (r == 0);
        n[7] = r[31];
        return n;
    endfunction

    // One operation: check the result at once, the status one cycle later
    task automatic step(input string req, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic upd);
        logic [31:0] exp_f;
        opnd_a = a; opnd_b = b; op_code = op; flag_upd_en = upd; fw_en = 1'b0;
        #1;
        chk({req, " result"}, alu_out, ref_res(op, a, b, model[0]));
        exp_f = upd ? ref_flags(op, a, b, model) : model;
        @(posedge clk); @(negedge clk);
        chk({req, " flags"}, flags_out, exp_f);
        model = exp_f;
        flag_upd_en = 1'b0;
    endtask

    task automatic wr_flags(input string req, input logic [31:0] d, input logic [31:0] exp);
        fw_en = 1'b1; fw_data = d; op_code = 3'd7; flag_upd_en = 1'b0;
        @(posedge clk); @(negedge clk);
        fw_en = 1'b0;
        chk(req, flags_out, exp);
        model = exp;
    endtask

    task automatic t_reset();
        chk("R12 reset value", flags_out, 32'h0000_0002);
    endtask

    task automatic t_add();
        step("R1 add small", 3'd0, 32'd1, 32'd1, 1'b1);
        step("R1 add wrap carry", 3'd0, 32'hFFFF_FFFF, 32'd1, 1'b1);
        step("R4 add signed overflow", 3'd0, 32'h7FFF_FFFF, 32'd1, 1'b1);
        step("R6 add half carry", 3'd0, 32'h0000_000F, 32'd1, 1'b1);
        chk("R6 half set", {31'd0, flags_out[4]}, 32'd1);
        chk("R4 overflow set", {31'd0, ref_flags(3'd0, 32'h7FFF_FFFF, 32'd1, 32'h2) >> 11 & 32'd1 ? 1'b1 : 1'b0}, 32'd1);
    endtask

    task automatic t_chain();
        step("R2 low word add", 3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1);
        chk("R2 carry stored", {31'd0, flags_out[0]}, 32'd1);
        step("R2 high word adc", 3'd1, 32'h0000_0000, 32'h0000_0000, 1'b1);
        step("R2 low word sub", 3'd2, 32'h0000_0000, 32'h0000_0001, 1'b1);
        step("R2 high word sbb", 3'd3, 32'h0000_0005, 32'h0000_0005, 1'b1);
        step("R3 sbb borrow all ones", 3'd3, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_sub();
        step("R3 sub equal zero", 3'd2, 32'h1234_5678, 32'h1234_5678, 1'b1);
        step("R3 sub borrow", 3'd2, 32'h0000_0000, 32'h0000_0001, 1'b1);
        step("R4 sub signed overflow", 3'd2, 32'h8000_0000, 32'h0000_0001, 1'b1);
        step("R6 sub half borrow", 3'd2, 32'h0000_0010, 32'h0000_0001, 1'b1);
        step("R7 sub sign", 3'd2, 32'h0000_0003, 32'h0000_0007, 1'b1);
    endtask

    task automatic t_parity();
        step("R5 parity high bytes ignored", 3'd5, 32'h0000_0100, 32'd0, 1'b1);
        step("R5 parity eight ones", 3'd5, 32'hFF00_00FF, 32'd0, 1'b1);
        step("R5 parity odd", 3'd5, 32'hFFFF_FF01, 32'd0, 1'b1);
        chk("R5 parity clear", {31'd0, flags_out[2]}, 32'd0);
    endtask

    task automatic t_logic();
        step("R6 preset half carry", 3'd0, 32'h0000_0008, 32'h0000_0008, 1'b1);
        step("R8 and", 3'd4, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 1'b1);
        chk("R8 half kept", {31'd0, flags_out[4]}, 32'd1);
        step("R1 add carry before xor", 3'd0, 32'hFFFF_FFFF, 32'h8000_0001, 1'b1);
        step("R8 xor clears carry", 3'd6, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1);
        step("R8 or", 3'd5, 32'h8000_0000, 32'h0000_0001, 1'b1);
    endtask

    task automatic t_hold();
        step("R9 carry before hold", 3'd0, 32'hFFFF_FFFF, 32'h0000_0002, 1'b1);
        step("R9 no update add", 3'd0, 32'h0000_0000, 32'h0000_0000, 1'b0);
        step("R9 no update xor", 3'd6, 32'h1234_5678, 32'h0000_0001, 1'b0);
        step("R13 unused code", 3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_write();
        wr_flags("R10 write all ones", 32'hFFFF_FFFF, 32'h003F_7FD7);
        wr_flags("R10 write zero", 32'h0000_0000, 32'h0000_0002);
        wr_flags("R11 set control bits", 32'h0000_3700, 32'h0000_3702);
        step("R11 add keeps control", 3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1);
        step("R11 sub keeps control", 3'd2, 32'h8000_0000, 32'h0000_0001, 1'b1);
        chk("R11 trap/int/dir kept", flags_out & 32'h0000_3700, 32'h0000_3700);
        // R10 priority: write and update in the same cycle
        opnd_a = 32'hFFFF_FFFF; opnd_b = 32'd1; op_code = 3'd0;
        flag_upd_en = 1'b1; fw_en = 1'b1; fw_data = 32'h0000_0400;
        @(posedge clk); @(negedge clk);
        fw_en = 1'b0; flag_upd_en = 1'b0;
        chk("R10 write beats update", flags_out, 32'h0000_0402);
        model = 32'h0000_0402;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_chain();
        t_sub();
        t_parity();
        t_logic();
        t_hold();
        t_write();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYC, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule